// File: doc/BRIEF.md
# SD/MMC Card Clock Generator with Update Handshake

This block derives the card clock of an SD/MMC host from the module clock. Software programs a clock control register holding an 8-bit divider, a clock enable and a power-save selector. Those values sit in a shadow copy and do nothing to the running clock by themselves. They move into the working copy only when the command register receives a word that has both the start flag and the update-clock flag set. That command never drives the card bus. Its start flag reads back as 1 until the new settings are in force.

The output runs at the module clock divided by twice the divider. A divider of zero passes the module clock straight through. All setting changes are applied while the card clock is low, and a high phase that has begun always runs to its full length. This keeps the output free of runt pulses, including across the usual disable, change, re-enable sequence. In power-save mode the clock stops low whenever no command or data transfer is in progress.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the card clock is low and idle, the start flag and done pulse are 0, and the control register reads 0.
- R2: The control register keeps the divider in bits [7:0], the enable in bit 16 and power-save in bit 17; all other bits read 0. Writing it without an update command leaves the card clock unchanged.
- R3: An update starts only on a command write with bit 31 (start) and bit 21 (update clock) both set. A command write lacking either bit leaves the start flag at 0.
- R4: The start flag reads 1 from the cycle after the update command. If the card clock is low, stopped or undivided, the flag clears after exactly one cycle. While a divided high phase is in progress it clears within divider+1 cycles. A one-cycle done pulse accompanies the clearing.
- R5: With a divider N of 1 or more, the card clock period is 2*N module clock periods, N high and N low. With N = 0 the card clock follows the module clock.
- R6: With the enable at 0 in the working copy, the card clock stays low.
- R7: With enable and power-save both set, the card clock stays low while the transfer-busy input is 0 and runs at the programmed rate while it is 1.
- R8: No high or low phase of the card clock is shorter than half a module clock period, including across a divider change made with the clock running.
- R9: The sequence disable/update, change divider/update, enable/update ends with the card clock at the period given by R5 for the new divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_en | input | 1 | Write strobe for the clock control register |
| ctrl_wr_data | input | 32 | Clock control write data |
| ctrl_rd_data | output | 32 | Clock control readback (shadow copy) |
| cmd_wr_en | input | 1 | Write strobe for the command register |
| cmd_wr_data | input | 32 | Command write data; bits 31 and 21 are decoded here |
| upd_busy | output | 1 | Start flag readback, 1 while an update is pending |
| upd_done | output | 1 | One-cycle pulse when the new settings take effect |
| xfer_busy | input | 1 | A command or data transfer is in progress |
| card_clk | output | 1 | Card clock |

## Verification
Suppose the shadow and working copies get confused. A write to the control register then changes the card clock period at once, and the period measured a few card-clock cycles later shows it. If the handshake state is wrong, the start flag either never clears or clears a cycle early, and the update latency measured at the port shows that one or two cycles after the command. If the low-phase guard is wrong, a direct divider switch or a switch into or out of pass-through mode leaves a pulse narrower than half a module period, and the next edge of the card clock catches it.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
  localparam int REG_W     = 32;
  localparam int DIV_W     = 8;
  localparam int ENA_BIT   = 16;
  localparam int PSV_BIT   = 17;
  localparam int START_BIT = 31;
  localparam int UPD_BIT   = 21;
endpackage

// File: rtl/sdclk_cfg.sv
`timescale 1ns/1ps
module sdclk_cfg #(
  parameter int REG_W = sdclk_pkg::REG_W,
  parameter int DIV_W = sdclk_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr_en,
  input  logic [REG_W-1:0] ctrl_wr_data,
  output logic [REG_W-1:0] ctrl_rd_data,
  input  logic             cmd_wr_en,
  input  logic [REG_W-1:0] cmd_wr_data,
  input  logic             clk_low_i,
  output logic             upd_busy,
  output logic             upd_done,
  output logic             apply_o,
  output logic [DIV_W-1:0] act_div,
  output logic             act_ena,
  output logic             act_psave
);
  import sdclk_pkg::*;

  localparam logic [REG_W-1:0] DIV_MASK  = REG_W'((64'd1 << DIV_W) - 64'd1);
  localparam logic [REG_W-1:0] CTRL_MASK = DIV_MASK | (REG_W'(1) << ENA_BIT)
                                           | (REG_W'(1) << PSV_BIT);
  localparam logic [REG_W-1:0] GO_MASK   = (REG_W'(1) << START_BIT)
                                           | (REG_W'(1) << UPD_BIT);

  logic [REG_W-1:0] shadow_q;
  logic             busy_q, done_q, go;
  logic [DIV_W-1:0] div_q;
  logic             ena_q, psave_q;

  assign go      = cmd_wr_en && ((cmd_wr_data & GO_MASK) == GO_MASK);
  assign apply_o = busy_q && clk_low_i;

  // shadow copy: software view only
  always_ff @(posedge clk) begin
    if (rst)             shadow_q <= '0;
    else if (ctrl_wr_en) shadow_q <= ctrl_wr_data & CTRL_MASK;
  end

  // handshake and working copy
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      div_q   <= '0;
      ena_q   <= 1'b0;
      psave_q <= 1'b0;
    end else begin
      done_q <= apply_o;
      if (go)           busy_q <= 1'b1;
      else if (apply_o) busy_q <= 1'b0;
      if (apply_o) begin
        div_q   <= shadow_q[DIV_W-1:0];
        ena_q   <= shadow_q[ENA_BIT];
        psave_q <= shadow_q[PSV_BIT];
      end
    end
  end

  assign ctrl_rd_data = shadow_q;
  assign upd_busy     = busy_q;
  assign upd_done     = done_q;
  assign act_div      = div_q;
  assign act_ena      = ena_q;
  assign act_psave    = psave_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    busy_q && clk_low_i && !go |=> !busy_q); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q)); // R4
  AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> $stable(div_q) && $stable(ena_q) && $stable(psave_q)); // R2
  AST_IGNORE_PARTIAL: assert property (@(posedge clk) disable iff (rst)
    cmd_wr_en && !go && !busy_q |=> !busy_q); // R3
endmodule

// File: rtl/sdclk_div.sv
`timescale 1ns/1ps
module sdclk_div #(
  parameter int DIV_W = sdclk_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  input  logic             apply_i,
  output logic             high_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             high_q;
  logic             last;

  assign last = (cnt_q == div_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || apply_i || div_i == '0) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (high_q) begin
      // a started high phase always completes
      if (last) begin
        cnt_q  <= '0;
        high_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (run_i) begin
      if (last) begin
        cnt_q  <= '0;
        high_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign high_o = high_q;

  AST_APPLY_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
    apply_i |-> !high_q); // R8
  AST_HIGH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $rose(high_q) && div_i > 1 |=> high_q); // R8
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
    !run_i && !high_q |=> !high_q); // R6
  AST_BYPASS_FLAT: assert property (@(posedge clk) disable iff (rst)
    div_i == '0 |=> !high_q); // R5
endmodule

// File: rtl/sdclk_out.sv
`timescale 1ns/1ps
module sdclk_out (
  input  logic clk,
  input  logic rst,
  input  logic bypass_run_i,
  input  logic div_high_i,
  output logic card_clk
);
  logic gate_q;

  // enable changes only while the module clock is low
  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= bypass_run_i;
  end

  assign card_clk = (clk & gate_q) | div_high_i;
endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
module sdclk_gen #(
  parameter int REG_W = sdclk_pkg::REG_W,
  parameter int DIV_W = sdclk_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr_en,
  input  logic [REG_W-1:0] ctrl_wr_data,
  output logic [REG_W-1:0] ctrl_rd_data,
  input  logic             cmd_wr_en,
  input  logic [REG_W-1:0] cmd_wr_data,
  output logic             upd_busy,
  output logic             upd_done,
  input  logic             xfer_busy,
  output logic             card_clk
);
  logic [DIV_W-1:0] act_div;
  logic             act_ena, act_psave, apply, div_high, run;

  sdclk_cfg #(.REG_W(REG_W), .DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst(rst),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd_data(ctrl_rd_data),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .clk_low_i(!div_high),
    .upd_busy(upd_busy), .upd_done(upd_done), .apply_o(apply),
    .act_div(act_div), .act_ena(act_ena), .act_psave(act_psave)
  );

  assign run = act_ena && (!act_psave || xfer_busy);

  sdclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div_i(act_div), .run_i(run),
    .apply_i(apply), .high_o(div_high)
  );

  sdclk_out u_out (
    .clk(clk), .rst(rst),
    .bypass_run_i(run && act_div == '0),
    .div_high_i(div_high), .card_clk(card_clk)
  );
endmodule

// File: tb/sdclk_gen_test.sv
`timescale 1ns/1ps
module sdclk_gen_test;
  logic        clk = 1'b0, rst = 1'b1;
  logic        ctrl_wr_en = 1'b0, cmd_wr_en = 1'b0, xfer_busy = 1'b0;
  logic [31:0] ctrl_wr_data = '0, cmd_wr_data = '0;
  logic [31:0] ctrl_rd_data;
  logic        upd_busy, upd_done, card_clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  sdclk_gen uut (
    .clk(clk), .rst(rst), .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
    .ctrl_rd_data(ctrl_rd_data), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .upd_busy(upd_busy), .upd_done(upd_done), .xfer_busy(xfer_busy), .card_clk(card_clk)
  );

  // card clock monitor: edge times and phase widths
  bit      mon_en = 0;
  int      rise_cnt = 0, runt_cnt = 0;
  realtime t_rise = 0, t_fall = 0, t_prev_rise = 0;

  always @(posedge card_clk) if (mon_en) begin
    if ($realtime - t_fall < 9.5) runt_cnt++;
    t_prev_rise = t_rise;
    t_rise = $realtime;
    rise_cnt++;
  end
  always @(negedge card_clk) if (mon_en) begin
    if ($realtime - t_rise < 9.5) runt_cnt++;
    t_fall = $realtime;
  end

  function automatic real exp_period(int d);
    return (d == 0) ? 20.0 : 40.0 * d;
  endfunction

  function automatic logic [31:0] exp_rd(logic [31:0] w);
    return w & 32'h0003_00FF;
  endfunction

  task automatic check_int(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_period(string req, real act, int d);
    real e = exp_period(d);
    checks++;
    if (act < e - 0.5 || act > e + 0.5) begin
      errors++;
      $display("FAIL %s period actual=%0.1f expected=%0.1f", req, act, e);
    end
  endtask

  task automatic wr_ctrl(logic [31:0] w);
    @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_data = w;
    @(negedge clk); ctrl_wr_en = 1'b0;
  endtask

  task automatic wr_cmd(logic [31:0] w);
    @(negedge clk); cmd_wr_en = 1'b1; cmd_wr_data = w;
    @(negedge clk); cmd_wr_en = 1'b0;
  endtask

  task automatic do_update(output int lat, output int done_seen);
    wr_cmd(32'h8020_0000);
    lat = 0;
    while (upd_busy && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    done_seen = int'(upd_done);
  endtask

  task automatic measure(output real per);
    int start = rise_cnt;
    int n = 0;
    while (rise_cnt < start + 3 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    per = (rise_cnt >= start + 3) ? (t_rise - t_prev_rise) : 0.0;
  endtask

  task automatic count_rises(int cycles, output int c);
    int start = rise_cnt;
    repeat (cycles) @(negedge clk);
    c = rise_cnt - start;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int lat, dn, c, cur_div, d;
    real per;
    logic [31:0] w;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_int("R1", "card_clk", int'(card_clk), 0);
    check_int("R1", "upd_busy", int'(upd_busy), 0);
    check_int("R1", "upd_done", int'(upd_done), 0);
    check_int("R1", "ctrl_rd_data", int'(ctrl_rd_data), 0);
    t_fall = $realtime; t_rise = $realtime - 20.0;
    mon_en = 1;
    count_rises(20, c);
    check_int("R1", "rises after reset", c, 0);

    // R2: readback mask, write alone has no effect
    wr_ctrl(32'hFFFF_FFFF);
    check_int("R2", "readback mask", int'(ctrl_rd_data), int'(exp_rd(32'hFFFF_FFFF)));
    count_rises(20, c);
    check_int("R2", "rises without update", c, 0);

    // R3: partial command words ignored
    wr_cmd(32'h8000_0000);
    check_int("R3", "busy on start-only", int'(upd_busy), 0);
    wr_cmd(32'h0020_0000);
    check_int("R3", "busy on update-only", int'(upd_busy), 0);
    count_rises(20, c);
    check_int("R3", "rises after partial commands", c, 0);

    // R4/R5: enable with divider 2 from stopped
    wr_ctrl(32'h0001_0002);
    do_update(lat, dn);
    check_int("R4", "latency from stopped", lat, 1);
    check_int("R4", "done pulse", dn, 1);
    @(negedge clk);
    check_int("R4", "done single cycle", int'(upd_done), 0);
    measure(per);
    check_period("R5", per, 2);

    // R2: shadow-only write while running
    wr_ctrl(32'h0001_0005);
    check_int("R2", "readback div 5", int'(ctrl_rd_data), 32'h0001_0005);
    measure(per);
    check_period("R2", per, 2);

    // R8/R4: direct switch while running
    do_update(lat, dn);
    checks++;
    if (lat < 1 || lat > 3) begin
      errors++;
      $display("FAIL R4 running latency actual=%0d expected=1..3", lat);
    end
    measure(per);
    check_period("R5", per, 5);

    // R5: pass-through
    wr_ctrl(32'h0001_0000);
    do_update(lat, dn);
    checks++;
    if (lat < 1 || lat > 6) begin
      errors++;
      $display("FAIL R4 latency into bypass actual=%0d expected=1..6", lat);
    end
    measure(per);
    check_period("R5", per, 0);

    wr_ctrl(32'h0001_0001);
    do_update(lat, dn);
    check_int("R4", "latency from bypass", lat, 1);
    measure(per);
    check_period("R5", per, 1);

    // R6: disable
    wr_ctrl(32'h0000_0001);
    do_update(lat, dn);
    repeat (4) @(negedge clk);
    count_rises(30, c);
    check_int("R6", "rises when disabled", c, 0);
    check_int("R6", "card_clk level disabled", int'(card_clk), 0);

    // R7: power-save, divided
    wr_ctrl(32'h0003_0003);
    do_update(lat, dn);
    check_int("R4", "latency stopped ps", lat, 1);
    count_rises(40, c);
    check_int("R7", "rises idle ps", c, 0);
    xfer_busy = 1'b1;
    measure(per);
    check_period("R7", per, 3);
    xfer_busy = 1'b0;
    repeat (10) @(negedge clk);
    count_rises(40, c);
    check_int("R7", "rises after transfer ends", c, 0);

    // R7: power-save, pass-through
    wr_ctrl(32'h0003_0000);
    do_update(lat, dn);
    repeat (2) @(negedge clk);
    count_rises(30, c);
    check_int("R7", "rises idle ps bypass", c, 0);
    xfer_busy = 1'b1;
    measure(per);
    check_period("R7", per, 0);
    @(negedge clk); xfer_busy = 1'b0;
    repeat (3) @(negedge clk);

    // R9: random safe reprogramming sequences
    void'($urandom(32'd1234));
    cur_div = 0;
    for (int i = 0; i < 8; i++) begin
      d = $urandom_range(0, 7);
      wr_ctrl({14'd0, 2'b00, 8'd0, 8'(cur_div)});
      do_update(lat, dn);
      checks++;
      if (lat < 1 || lat > cur_div + 1) begin
        errors++;
        $display("FAIL R4 disable latency actual=%0d expected=1..%0d", lat, cur_div + 1);
      end
      wr_ctrl({24'd0, 8'(d)});
      do_update(lat, dn);
      check_int("R9", "latency divider step", lat, 1);
      wr_ctrl({14'd0, 2'b01, 8'd0, 8'(d)});
      do_update(lat, dn);
      check_int("R9", "latency enable step", lat, 1);
      measure(per);
      check_period("R9", per, d);
      w = ($urandom() | 32'h8000_0000) & ~32'h0020_0000;
      wr_cmd(w);
      check_int("R3", "random partial command", int'(upd_busy), 0);
      cur_div = d;
    end

    repeat (20) @(negedge clk);
    check_int("R8", "runt pulses", runt_cnt, 0);
    summary();
  end
endmodule